// File: doc/BRIEF.md
# Multi-thread GPR scalar unit

This block holds the general-purpose registers of three hardware threads, one bank of sixty-four 32-bit registers per thread. It also contains a scalar unit that runs short instruction words against those banks. An instruction can load a 16-bit half of one register from an immediate, add two values, multiply two values, or do nothing. Each thread presents its instructions on its own valid/ready port. A round-robin arbiter admits one instruction at a time, and the unit runs it to completion with no overlap. While it runs, the unit holds a `busy` flag that neighbouring units wait on before they consume a register.

A host bus port reads and writes any register in any bank by byte offset. Its read data arrives one cycle after the request. Firmware typically preloads constants through either path. It then waits for `busy` to drop before another unit copies the registers onward.

Top module: `gpr_scalar_unit`

## Requirements
- R1: After reset `busy`, `err` and `host_rdata` are 0 and every register of every bank reads as zero.
- R2: A set-half word (bits [31:24]=0x45, bit 7=0, bits [23:22]=0) writes its zero-extended 14-bit immediate (bits [21:8]) into one half of a register chosen by the 7-bit index in bits [6:0]. Index 2n selects the low 16 bits of register n and index 2n+1 selects the high 16 bits. The other half is left unchanged.
- R3: An add word (bits [31:24]=0x58, bits [22:18]=0) writes A+B, modulo 2^32, to the register in bits [17:12]. A is the register in bits [5:0]. B is the register in bits [11:6], or, when bit 23 is 1, the 6-bit unsigned constant in bits [11:6].
- R4: A multiply word (0x5A, same fields as the add word) writes the full 32-bit unsigned product of the low 16 bits of A and the low 16 bits of B.
- R5: Once accepted, an instruction holds `busy` high for exactly its latency, counted in cycles. Set-half and no-op (0x60, bits [23:0]=0) take 1 cycle. Add and multiply take 3 cycles when B is a constant or when A and B have the same index bits [5:2], and 4 cycles otherwise.
- R6: An instruction from thread t reads and writes only bank t.
- R7: Host byte offset t*0x100 + r*4 addresses register r of bank t. Read data appears on `host_rdata` on the cycle after `host_re`. An offset with a bank number of 3 or higher, or with nonzero bits [1:0], reads as zero and is ignored on write.
- R8: Among the threads whose valid is high, a round-robin arbiter grants the one that follows the last granted thread. At most one ready is high at a time. A ready is high only together with its valid, and only while the unit is idle or in the last cycle of its current instruction.
- R9: A set-half word with bit 7 set is accepted and treated as a 1-cycle no-op. It changes no register and raises no `err`.
- R10: A word with an unknown opcode, or with a nonzero reserved field, is accepted and occupies the unit for 1 cycle. It changes no register and raises `err` for one cycle at its completion.
- R11: When a host write and an instruction write reach the same register in the same cycle, the host write is dropped and the instruction result stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_valid | input | NTHR | Per-thread instruction valid |
| thr_instr | input | 32*NTHR | Per-thread instruction words, thread i at bits [32i+31:32i] |
| thr_ready | output | NTHR | Per-thread accept, one-hot or zero |
| busy | output | 1 | Unit occupied by an instruction |
| err | output | 1 | One-cycle pulse for a rejected word |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 10 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after `host_re` |

## Verification
The clash that matters here is a host write and a retiring instruction writing the same register on the same clock edge. To provoke it, the bench starts a host write of all ones in exactly the cycle a set-half instruction retires into that register. A readback then shows whether the result holds the instruction's half together with the untouched prior value of the other half. A second overlap is several thread ports asking in the same cycle. The bench judges that case from the order in which the ports are accepted, comparing it against the rotating priority.

// File: rtl/gsu_pkg.sv
package gsu_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned RIDX_W = 6;
  localparam int unsigned HIDX_W = 7;

  localparam logic [7:0] OP_SETHALF = 8'h45;
  localparam logic [7:0] OP_ADD     = 8'h58;
  localparam logic [7:0] OP_MUL     = 8'h5A;
  localparam logic [7:0] OP_NOP     = 8'h60;

  typedef enum logic [2:0] {
    K_IDLE,
    K_SETH,
    K_ADD,
    K_MUL,
    K_BAD
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              b_const;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] ra;
    logic [HIDX_W-1:0] hidx;
    logic [15:0]       imm16;
  } uop_t;
endpackage

// File: rtl/gsu_decode.sv
module gsu_decode
  import gsu_pkg::*;
#(
  parameter int unsigned LAT_SHORT = 3,
  parameter int unsigned LAT_LONG  = 4,
  parameter int unsigned CW        = $clog2(LAT_LONG + 1)
) (
  input  logic [INSN_W-1:0] instr,
  output uop_t              uop,
  output logic [CW-1:0]     lat
);
  logic [7:0] opc;
  logic       same_grp;

  assign opc      = instr[31:24];
  assign same_grp = (instr[11:8] == instr[5:2]);

  always_comb begin
    uop         = '0;
    uop.kind    = K_BAD;
    uop.b_const = instr[23];
    uop.rd      = instr[17:12];
    uop.rb      = instr[11:6];
    uop.ra      = instr[5:0];
    uop.hidx    = instr[6:0];
    uop.imm16   = {2'b00, instr[21:8]};
    lat         = CW'(1);
    unique case (opc)
      OP_SETHALF: begin
        if (instr[23:22] != 2'b00) uop.kind = K_BAD;
        else if (instr[7])         uop.kind = K_IDLE;
        else                       uop.kind = K_SETH;
      end
      OP_ADD, OP_MUL: begin
        if (instr[22:18] != 5'd0) begin
          uop.kind = K_BAD;
        end else begin
          uop.kind = (opc == OP_ADD) ? K_ADD : K_MUL;
          lat = (instr[23] || same_grp) ? CW'(LAT_SHORT) : CW'(LAT_LONG);
        end
      end
      OP_NOP: begin
        uop.kind = (instr[23:0] == 24'd0) ? K_IDLE : K_BAD;
      end
      default: uop.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/gsu_rr_arb.sv
module gsu_rr_arb #(
  parameter int unsigned N  = 3,
  parameter int unsigned TW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [TW-1:0] gidx
);
  logic [TW-1:0] last_q;
  logic          found;

  always_comb begin
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    for (int i = 1; i <= int'(N); i++) begin
      int j;
      j = int'(last_q) + i;
      if (j >= int'(N)) j = j - int'(N);
      if (!found && req[j]) begin
        found  = 1'b1;
        gnt[j] = en;
        gidx   = TW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             last_q <= TW'(N - 1);
    else if (|gnt)       last_q <= gidx;
  end
endmodule

// File: rtl/gsu_regfile.sv
module gsu_regfile #(
  parameter int unsigned NTHR  = 3,
  parameter int unsigned IW    = 8,
  parameter int unsigned DEPTH = NTHR * 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ra_idx,
  input  logic [IW-1:0] rb_idx,
  output logic [31:0]   ra_data,
  output logic [31:0]   rb_data,
  input  logic          ex_we,
  input  logic [IW-1:0] ex_idx,
  input  logic [1:0]    ex_hmask,
  input  logic [31:0]   ex_wdata,
  input  logic          h_we,
  input  logic          h_re,
  input  logic          h_ok,
  input  logic [IW-1:0] h_idx,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata
);
  logic [31:0] mem [DEPTH];
  logic        h_clash;

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
  assign h_clash = ex_we && (ex_idx == h_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      h_rdata <= '0;
    end else begin
      if (h_we && h_ok && !h_clash) mem[h_idx] <= h_wdata;
      if (ex_we && ex_hmask[0]) mem[ex_idx][15:0]  <= ex_wdata[15:0];
      if (ex_we && ex_hmask[1]) mem[ex_idx][31:16] <= ex_wdata[31:16];
      h_rdata <= (h_re && h_ok) ? mem[h_idx] : '0;
    end
  end
endmodule

// File: rtl/gpr_scalar_unit.sv
module gpr_scalar_unit
  import gsu_pkg::*;
#(
  parameter int unsigned NTHR      = 3,
  parameter int unsigned LAT_SHORT = 3,
  parameter int unsigned LAT_LONG  = 4,
  parameter int unsigned TW        = (NTHR > 1) ? $clog2(NTHR) : 1,
  parameter int unsigned HAW       = TW + 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NTHR-1:0]        thr_valid,
  input  logic [NTHR*INSN_W-1:0] thr_instr,
  output logic [NTHR-1:0]        thr_ready,
  output logic                   busy,
  output logic                   err,
  input  logic                   host_we,
  input  logic                   host_re,
  input  logic [HAW-1:0]         host_addr,
  input  logic [31:0]            host_wdata,
  output logic [31:0]            host_rdata
);
  localparam int unsigned CW = $clog2(LAT_LONG + 1);
  localparam int unsigned IW = TW + RIDX_W;

  logic [CW-1:0]     cnt_q, cnt_n, dec_lat;
  logic              can_issue, accept, retire;
  logic [NTHR-1:0]   gnt;
  logic [TW-1:0]     gidx;
  logic [INSN_W-1:0] sel_ins;
  uop_t              dec_uop, cur_q;
  logic [TW-1:0]     tid_q;

  logic [IW-1:0]     ra_idx, rb_idx, ex_idx, h_idx;
  logic [31:0]       ra_data, rb_data, opb, ex_wdata;
  logic              ex_we, h_ok;
  logic [1:0]        ex_hmask;

  assign can_issue = (cnt_q <= CW'(1));
  assign retire    = (cnt_q == CW'(1));

  gsu_rr_arb #(.N(NTHR), .TW(TW)) u_arb (
    .clk (clk), .rst (rst), .req (thr_valid), .en (can_issue),
    .gnt (gnt), .gidx (gidx)
  );

  assign thr_ready = gnt;
  assign accept    = |gnt;

  always_comb begin
    sel_ins = '0;
    for (int i = 0; i < int'(NTHR); i++)
      if (gnt[i]) sel_ins = thr_instr[i*INSN_W +: INSN_W];
  end

  gsu_decode #(.LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG), .CW(CW)) u_dec (
    .instr (sel_ins), .uop (dec_uop), .lat (dec_lat)
  );

  always_comb begin
    cnt_n = cnt_q;
    if (accept)                cnt_n = dec_lat;
    else if (cnt_q != '0)      cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      err   <= 1'b0;
      cur_q <= '0;
      tid_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      busy  <= (cnt_n != '0);
      err   <= retire && (cur_q.kind == K_BAD);
      if (accept) begin
        cur_q <= dec_uop;
        tid_q <= gidx;
      end
    end
  end

  // Execution at retirement: operands are read in the final busy cycle.
  assign ra_idx = {tid_q, cur_q.ra};
  assign rb_idx = {tid_q, cur_q.rb};
  assign opb    = cur_q.b_const ? {26'd0, cur_q.rb} : rb_data;

  always_comb begin
    ex_we    = 1'b0;
    ex_idx   = {tid_q, cur_q.rd};
    ex_hmask = 2'b11;
    ex_wdata = ra_data + opb;
    unique case (cur_q.kind)
      K_SETH: begin
        ex_we    = retire;
        ex_idx   = {tid_q, cur_q.hidx[HIDX_W-1:1]};
        ex_hmask = cur_q.hidx[0] ? 2'b10 : 2'b01;
        ex_wdata = {cur_q.imm16, cur_q.imm16};
      end
      K_ADD: ex_we = retire;
      K_MUL: begin
        ex_we    = retire;
        ex_wdata = 32'(ra_data[15:0]) * 32'(opb[15:0]);
      end
      default: ex_we = 1'b0;
    endcase
  end

  assign h_ok  = (host_addr[HAW-1:8] < (HAW-8)'(NTHR)) && (host_addr[1:0] == 2'b00);
  assign h_idx = {host_addr[HAW-1:8], host_addr[7:2]};

  gsu_regfile #(.NTHR(NTHR), .IW(IW)) u_rf (
    .clk (clk), .rst (rst),
    .ra_idx (ra_idx), .rb_idx (rb_idx), .ra_data (ra_data), .rb_data (rb_data),
    .ex_we (ex_we), .ex_idx (ex_idx), .ex_hmask (ex_hmask), .ex_wdata (ex_wdata),
    .h_we (host_we), .h_re (host_re), .h_ok (h_ok), .h_idx (h_idx),
    .h_wdata (host_wdata), .h_rdata (host_rdata)
  );
endmodule

// File: rtl/gsu_chk.sv
module gsu_chk #(
  parameter int unsigned NTHR = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NTHR-1:0] thr_valid,
  input logic [NTHR-1:0] thr_ready,
  input logic            busy,
  input logic            err
);
  // R8
  ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(thr_ready));

  // R8
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ((thr_ready & ~thr_valid) == '0));

  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (|(thr_valid & thr_ready)) |=> busy);

  // R10
  err_after_work_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(busy));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !err));
endmodule

bind gpr_scalar_unit gsu_chk #(.NTHR(NTHR)) u_chk (
  .clk (clk), .rst (rst), .thr_valid (thr_valid), .thr_ready (thr_ready),
  .busy (busy), .err (err)
);

// File: tb/gpr_scalar_unit_tb.sv
module gpr_scalar_unit_tb;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NT-1:0] tb_valid = '0;
  logic [31:0]   tb_ins [NT];
  logic [NT*32-1:0] thr_instr;
  logic [NT-1:0] thr_ready;
  logic          busy, err;
  logic          host_we = 1'b0, host_re = 1'b0;
  logic [9:0]    host_addr = '0;
  logic [31:0]   host_wdata = '0, host_rdata;

  int checks = 0, fails = 0;
  logic [31:0] model [NT][64];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          acc_log [$];
  logic        rd_v = 1'b0;

  always #5 clk = ~clk;
  assign thr_instr = {tb_ins[2], tb_ins[1], tb_ins[0]};

  gpr_scalar_unit u_dut (
    .clk (clk), .rst (rst), .thr_valid (tb_valid), .thr_instr (thr_instr),
    .thr_ready (thr_ready), .busy (busy), .err (err),
    .host_we (host_we), .host_re (host_re), .host_addr (host_addr),
    .host_wdata (host_wdata), .host_rdata (host_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data one cycle after each host read.
  always @(posedge clk) rd_v <= host_re;
  always @(negedge clk) begin
    if (rd_v) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 actual=%h expected=none", host_rdata);
      end else begin
        check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk)
    for (int i = 0; i < NT; i++)
      if (tb_valid[i] && thr_ready[i]) acc_log.push_back(i);

  function automatic logic [9:0] hoff(int t, int r);
    return 10'(t * 256 + r * 4);
  endfunction
  function automatic logic [31:0] w_set(int hidx, logic [13:0] imm, logic mode);
    return {8'h45, 2'b00, imm, mode, 7'(hidx)};
  endfunction
  function automatic logic [31:0] w_ar(logic [7:0] op, logic k, int rd, int b, int a);
    return {op, k, 5'd0, 6'(rd), 6'(b), 6'(a)};
  endfunction

  task automatic host_write(logic [9:0] a, logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic host_read(logic [9:0] a, logic [31:0] exp, string tag);
    @(negedge clk); host_re = 1'b1; host_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); host_re = 1'b0;
  endtask

  task automatic issue(int t, logic [31:0] w);
    @(negedge clk); tb_valid[t] = 1'b1; tb_ins[t] = w;
    #1;
    while (!thr_ready[t]) begin @(negedge clk); #1; end
    @(negedge clk); tb_valid[t] = 1'b0;
  endtask

  task automatic issue_lat(int t, logic [31:0] w, int exp_lat, string tag);
    int n = 0;
    issue(t, w);
    while (busy) begin n++; @(negedge clk); end
    check(tag, 32'(n), 32'(exp_lat));
  endtask

  // Reference: apply a valid instruction from the requirements.
  task automatic model_exec(int t, logic [31:0] w);
    logic [31:0] a, b;
    a = model[t][w[5:0]];
    b = w[23] ? {26'd0, w[11:6]} : model[t][w[11:6]];
    case (w[31:24])
      8'h45: if (!w[7]) begin
        if (w[0]) model[t][w[6:1]][31:16] = {2'b00, w[21:8]};
        else      model[t][w[6:1]][15:0]  = {2'b00, w[21:8]};
      end
      8'h58: model[t][w[17:12]] = a + b;
      8'h5A: model[t][w[17:12]] = {16'd0, a[15:0]} * {16'd0, b[15:0]};
      default: ;
    endcase
  endtask

  task automatic run(int t, logic [31:0] w, int lat, string tag);
    issue_lat(t, w, lat, tag);
    model_exec(t, w);
  endtask

  initial begin
    #(10 * 100000);
    fails++; checks++;
    $display("FAIL R5 watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    for (int t = 0; t < NT; t++) begin
      tb_ins[t] = '0;
      for (int r = 0; r < 64; r++) model[t][r] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
    check("R1 rdata", host_rdata, 32'd0);
    host_read(hoff(0, 0), 32'd0, "R1 t0r0");
    host_read(hoff(2, 63), 32'd0, "R1 t2r63");

    // R8 simultaneous requests, first round from reset priority
    acc_log.delete();
    fork
      issue(0, w_set(2, 14'h11, 1'b0));
      issue(1, w_set(2, 14'h22, 1'b0));
      issue(2, w_set(2, 14'h33, 1'b0));
    join
    for (int t = 0; t < NT; t++) model_exec(t, w_set(2, 14'h11 * 14'(t + 1), 1'b0));
    check("R8 order", {acc_log[0][7:0], acc_log[1][7:0], acc_log[2][7:0]}, 32'h000102);
    issue(0, w_set(3, 14'h1, 1'b0)); model_exec(0, w_set(3, 14'h1, 1'b0));
    acc_log.delete();
    fork
      issue(0, {8'h60, 24'd0});
      issue(1, {8'h60, 24'd0});
      issue(2, {8'h60, 24'd0});
    join
    check("R8 rotate", {acc_log[0][7:0], acc_log[1][7:0], acc_log[2][7:0]}, 32'h010200);
    // R6 each bank got only its own thread's write
    for (int t = 0; t < NT; t++) host_read(hoff(t, 1), model[t][1], "R6 bank");
    host_read(hoff(0, 1), 32'h0001_0011, "R2 low/high");

    // R2 half writes, max immediate
    run(0, w_set(2 * 20 + 1, 14'h3FFF, 1'b0), 1, "R5 sethalf lat");
    run(0, w_set(2 * 20, 14'h0ABC, 1'b0), 1, "R5 sethalf lat2");
    host_read(hoff(0, 20), 32'h3FFF_0ABC, "R2 both halves");
    run(0, {8'h60, 24'd0}, 1, "R5 nop lat");

    // R3/R4 arithmetic, R5 latencies
    host_write(hoff(0, 4), 32'hFFFF_FFF0); model[0][4] = 32'hFFFF_FFF0;
    host_write(hoff(0, 5), 32'h0000_0020); model[0][5] = 32'h0000_0020;
    host_write(hoff(0, 9), 32'h0003_FFFF); model[0][9] = 32'h0003_FFFF;
    host_read(hoff(0, 4), 32'hFFFF_FFF0, "R7 host write");
    run(0, w_ar(8'h58, 1'b0, 6, 5, 4), 3, "R5 add same group");
    host_read(hoff(0, 6), 32'h0000_0010, "R3 add wrap");
    run(0, w_ar(8'h58, 1'b1, 7, 63, 4), 3, "R5 add const");
    host_read(hoff(0, 7), model[0][7], "R3 add const");
    run(0, w_ar(8'h58, 1'b0, 10, 9, 4), 4, "R5 add cross group");
    host_read(hoff(0, 10), model[0][10], "R3 add regs");
    run(0, w_ar(8'h5A, 1'b0, 8, 9, 4), 4, "R5 mul cross group");
    host_read(hoff(0, 8), 32'hFFEF_0010, "R4 mul");
    run(0, w_ar(8'h5A, 1'b1, 11, 7, 5), 3, "R5 mul const");
    host_read(hoff(0, 11), 32'h0000_00E0, "R4 mul const");

    // R6 thread 2 arithmetic does not touch bank 0
    run(2, w_ar(8'h58, 1'b1, 6, 1, 4), 3, "R5 add t2");
    host_read(hoff(2, 6), 32'h0000_0001, "R6 t2 add");
    host_read(hoff(0, 6), 32'h0000_0010, "R6 t0 kept");

    // R9 mode bit
    run(1, w_set(2 * 30, 14'h1234, 1'b1), 1, "R9 lat");
    check("R9 err", {31'd0, err}, 32'd0);
    host_read(hoff(1, 30), 32'd0, "R9 no write");

    // R10 unknown opcode and reserved bits
    issue(1, 32'h7F00_0041);
    check("R10 err late", {31'd0, err}, 32'd0);
    @(negedge clk);
    check("R10 err pulse", {31'd0, err}, 32'd1);
    @(negedge clk);
    check("R10 err clear", {31'd0, err}, 32'd0);
    issue(1, {8'h58, 1'b0, 5'b00100, 6'd12, 6'd1, 6'd1});
    @(negedge clk);
    check("R10 reserved err", {31'd0, err}, 32'd1);
    host_read(hoff(1, 12), 32'd0, "R10 no write");

    // R7 out-of-range and misaligned host accesses
    host_write(hoff(0, 0), 32'h5A5A_0001); model[0][0] = 32'h5A5A_0001;
    host_write(10'h300, 32'hDEAD_BEEF);
    host_write(hoff(0, 0) | 10'd2, 32'hCAFE_F00D);
    host_read(hoff(0, 0), 32'h5A5A_0001, "R7 ignored writes");
    host_read(10'h300, 32'd0, "R7 bank3 read");

    // R11 host write and instruction retire in the same cycle
    host_write(hoff(0, 40), 32'hABCD_5555);
    issue(0, w_set(80, 14'h1234, 1'b0));
    host_we = 1'b1; host_addr = hoff(0, 40); host_wdata = 32'hFFFF_FFFF;
    @(negedge clk); host_we = 1'b0;
    host_read(hoff(0, 40), 32'hABCD_1234, "R11 clash");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule